// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block is a synthesizable behavioural model of the command interpreter that sits behind the pins of an asynchronous parallel NOR flash. The pins are sampled on a system clock. A host writes multi-cycle command sequences over the chip-enable, write-enable, output-enable, address and data pins. The block decodes these sequences and switches between array reads, identifier reads, word or byte programming, sector and whole-device erase, erase suspend and resume, and a fast-program mode that needs only two writes for each program.

The storage is a small register array. Program and erase last for a configurable number of clock cycles. While one of them runs, a read returns a status byte instead of array data. Taking the chip-enable away does not stop the running operation. An active-low hardware reset aborts any operation, disables the outputs and puts the interpreter back into array-read mode. The array contents are kept across the reset.

Top module: `flash_cmd_top`

## Requirements
- R1: A write is taken once, at the first clock where ce_n=0, we_n=0 and oe_n=1 are all seen together. A write strobe given with oe_n=0 is ignored.
- R2: A standard program is AA at address 0x15, 55 at 0x2A, A0 at 0x15, then the data at the target address. Command values are compared on din[7:0]. Programming can only clear bits, so the stored word becomes the old word AND the new data.
- R3: A write whose address/data pair does not match the expected next step of a sequence sends the interpreter back to array-read mode, and the sequence has no effect.
- R4: AA@0x15, 55@0x2A, 20@0x15 enters the fast-program mode. In this mode, A0 at any address followed by the data at the target programs in two writes. 90 followed by 00 leaves the mode.
- R5: AA@0x15, 55@0x2A, 90@0x15 enters identifier mode. Reads then return the maker code 0x5A at addr[1:0]=0 and the device code 0xB9 at addr[1:0]=1, both on dout[7:0] with the upper bits zero. A write of F0 returns to array reads.
- R6: While a program or an erase runs, a read returns dout[15:8]=0 and dout[5:0]=0. dout[6] inverts after each such read. dout[7] is the complement of data bit 7 during a program and 0 during an erase.
- R7: Erase setup is AA@0x15, 55@0x2A, 80@0x15, AA@0x15, 55@0x2A. A 30 written at an address then marks the sector named by addr[5:4]. Further 30 writes within 24 cycles of the last one add more sectors. The marked sectors become all ones and the others keep their data.
- R8: A 10 written at 0x15 after the erase setup erases the whole array to all ones.
- R9: A B0 write during a running erase suspends it. While suspended, reads return array data and the erase does not finish. A 30 write resumes the erase, which then completes.
- R10: While rst_n is low, dout_en is 0 and writes are ignored. A program interrupted by reset leaves its target unchanged, and array reads follow the release.
- R11: A program or erase runs to completion while ce_n is high.
- R12: With byte_n=0, program data is din[7:0] and is written to the byte chosen by byte_sel (1 = upper). Reads return that byte on dout[7:0] with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_n | input | 1 | 0 selects byte-wide data, 1 selects word-wide data |
| byte_sel | input | 1 | In byte mode, selects the upper (1) or lower (0) byte |
| addr | input | 6 | Word address |
| din | input | 16 | Write data and command code |
| dout | output | 16 | Read data, identifier or status |
| dout_en | output | 1 | Output drive enable; 0 means the outputs float |

## Verification
The command decoder is tested with complete standard sequences, a sequence with one wrong unlock address, a data strobe made with output-enable low, and the shortened two-write program. Together these show that each sequence step is matched on both address and data and that a broken sequence leaves no trace. Programming over data that is already there shows AND-only behaviour rather than a plain overwrite. Erases are run on the whole device and on a pair of sectors, plus one erase that is suspended and then resumed, to show that sector selection and the pause are correct. Reads taken during operations show the status bits and their toggling. A reset that lands in the middle of a program shows that the operation is aborted.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        S_READ, S_UL1, S_UL2, S_PDATA,
        S_ESET, S_EU1, S_EU2, S_ECOL,
        S_BPROG, S_BERS, S_SUSP, S_ASEL,
        S_BYP, S_BYPPROG, S_BYPEXIT
    } fsm_st_t;

    localparam logic [7:0] CMD_KEY1   = 8'hAA;
    localparam logic [7:0] CMD_KEY2   = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_FAST   = 8'h20;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_PAUSE  = 8'hB0;
    localparam logic [7:0] CMD_QUIT   = 8'hF0;
    localparam logic [7:0] CMD_FASTX  = 8'h00;

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    input  logic          hold,
    output logic          done
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = len;
        else if (cnt_q != '0 && !hold)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CW'(1)) && !hold;

    // R9: a paused count does not move
    p_pause_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !start) |=> $stable(cnt_q));

endmodule

// File: rtl/flash_store.sv
module flash_store #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int SB = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_we,
    input  logic [AW-1:0]       prog_addr,
    input  logic [DW-1:0]       prog_word,
    input  logic                ers_we,
    input  logic [(1<<SB)-1:0]  ers_sect,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);

    localparam int DEPTH = 1 << AW;
    localparam int NSECT = 1 << SB;
    localparam int WPS   = DEPTH / NSECT;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (ers_we && ers_sect[i / WPS])
                mem_d[i] = '1;
        end
        if (prog_we)
            mem_d[prog_addr] = mem_q[prog_addr] & prog_word;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++)
            mem_q[i] <= mem_d[i];
    end

    assign rd_data = mem_q[rd_addr];

    // R2: a program never raises a bit
    p_prog_clears_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> ((mem_q[$past(prog_addr)] & ~$past(mem_q[prog_addr])) == '0));

    // R8: whole-device erase leaves both ends of the array all ones
    p_chip_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_we && ers_sect == '1) |=> (mem_q[0] == '1 && mem_q[DEPTH-1] == '1));

    // R7: program and erase never commit in the same cycle
    p_one_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_we, ers_we}));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int            AW        = 6,
    parameter int            DW        = 16,
    parameter int            SB        = 2,
    parameter int            CW        = 8,
    parameter int            PROG_CYC  = 16,
    parameter int            ERASE_CYC = 64,
    parameter int            ERS_WIN   = 24,
    parameter logic [AW-1:0] UL_A1     = 'h15,
    parameter logic [AW-1:0] UL_A2     = 'h2A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                byte_n,
    input  logic                byte_sel,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       din,
    input  logic                tmr_done,
    output logic                tmr_start,
    output logic [CW-1:0]       tmr_len,
    output logic                tmr_hold,
    output logic                prog_we,
    output logic [AW-1:0]       prog_addr,
    output logic [DW-1:0]       prog_word,
    output logic                ers_we,
    output logic [(1<<SB)-1:0]  ers_sect,
    output logic                busy,
    output logic                ident,
    output logic [7:0]          stat
);

    localparam int NSECT = 1 << SB;
    localparam int HB    = DW / 2;

    typedef struct packed {
        fsm_st_t          st;
        logic             fast;
        logic             wr_prev;
        logic             rd_prev;
        logic             tog;
        logic             pd7;
        logic [AW-1:0]    paddr;
        logic [DW-1:0]    pword;
        logic [NSECT-1:0] smask;
    } ctl_t;

    ctl_t q, d;

    logic          wr_act, rd_act, wr;
    logic          at1, key1, key2;
    logic [7:0]    cmd;
    logic [SB-1:0] sect;
    logic [DW-1:0] word_in;
    fsm_st_t       home;

    always_comb begin
        d         = q;
        tmr_start = 1'b0;
        tmr_len   = '0;
        prog_we   = 1'b0;
        ers_we    = 1'b0;

        wr_act    = !ce_n && !we_n && oe_n;
        rd_act    = !ce_n && !oe_n && we_n;
        wr        = wr_act && !q.wr_prev;
        d.wr_prev = wr_act;
        d.rd_prev = rd_act;

        cmd  = din[7:0];
        at1  = (addr == UL_A1);
        key1 = at1 && cmd == CMD_KEY1;
        key2 = (addr == UL_A2) && cmd == CMD_KEY2;
        sect = addr[AW-1 -: SB];
        home = q.fast ? S_BYP : S_READ;
        word_in = byte_n ? din :
                  (byte_sel ? {din[HB-1:0], {HB{1'b1}}} : {{HB{1'b1}}, din[HB-1:0]});

        busy = (q.st == S_BPROG) || (q.st == S_BERS) || (q.st == S_ECOL);
        if (busy && q.rd_prev && !rd_act)
            d.tog = !q.tog;

        case (q.st)
            S_READ: if (wr && key1) d.st = S_UL1;
            S_UL1:  if (wr) d.st = key2 ? S_UL2 : S_READ;
            S_UL2:  if (wr) begin
                d.st = S_READ;
                if (at1) begin
                    case (cmd)
                        CMD_PROG:  d.st = S_PDATA;
                        CMD_ERASE: d.st = S_ESET;
                        CMD_IDENT: d.st = S_ASEL;
                        CMD_FAST:  begin d.st = S_BYP; d.fast = 1'b1; end
                        default:   d.st = S_READ;
                    endcase
                end
            end
            S_PDATA, S_BYPPROG: if (wr) begin
                d.paddr   = addr;
                d.pword   = word_in;
                d.pd7     = din[7];
                d.st      = S_BPROG;
                tmr_start = 1'b1;
                tmr_len   = CW'(PROG_CYC);
            end
            S_ESET: if (wr) d.st = key1 ? S_EU1 : S_READ;
            S_EU1:  if (wr) d.st = key2 ? S_EU2 : S_READ;
            S_EU2:  if (wr) begin
                d.st = S_READ;
                if (at1 && cmd == CMD_CHIP) begin
                    d.smask   = '1;
                    d.st      = S_BERS;
                    tmr_start = 1'b1;
                    tmr_len   = CW'(ERASE_CYC);
                end else if (cmd == CMD_SECT) begin
                    d.smask       = '0;
                    d.smask[sect] = 1'b1;
                    d.st          = S_ECOL;
                    tmr_start     = 1'b1;
                    tmr_len       = CW'(ERS_WIN);
                end
            end
            S_ECOL: begin
                if (wr) begin
                    if (cmd == CMD_SECT) begin
                        d.smask[sect] = 1'b1;
                        tmr_start     = 1'b1;
                        tmr_len       = CW'(ERS_WIN);
                    end else begin
                        d.smask = '0;
                        d.st    = S_READ;
                    end
                end else if (tmr_done) begin
                    d.st      = S_BERS;
                    tmr_start = 1'b1;
                    tmr_len   = CW'(ERASE_CYC);
                end
            end
            S_BERS: begin
                if (wr && cmd == CMD_PAUSE)
                    d.st = S_SUSP;
                else if (tmr_done) begin
                    ers_we = 1'b1;
                    d.st   = S_READ;
                end
            end
            S_SUSP: if (wr && cmd == CMD_SECT) d.st = S_BERS;
            S_BPROG: if (tmr_done) begin
                prog_we = 1'b1;
                d.st    = home;
            end
            S_ASEL: if (wr && cmd == CMD_QUIT) d.st = S_READ;
            S_BYP: if (wr) begin
                if (cmd == CMD_PROG)       d.st = S_BYPPROG;
                else if (cmd == CMD_IDENT) d.st = S_BYPEXIT;
            end
            S_BYPEXIT: if (wr) begin
                if (cmd == CMD_FASTX) begin
                    d.st   = S_READ;
                    d.fast = 1'b0;
                end else begin
                    d.st = S_BYP;
                end
            end
            default: d.st = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tmr_hold  = (q.st == S_SUSP);
    assign prog_addr = q.paddr;
    assign prog_word = q.pword;
    assign ers_sect  = q.smask;
    assign ident     = (q.st == S_ASEL);
    assign stat      = {(q.st == S_BPROG) ? !q.pd7 : 1'b0, q.tog, 6'b0};

    // R2: the program phase ends when the timer expires
    p_prog_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_BPROG && tmr_done) |=> (q.st != S_BPROG));

    // R7: a sector window that runs out without a write starts the erase
    p_window_to_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ECOL && tmr_done && !wr) |=> (q.st == S_BERS));

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top #(
    parameter int            AW        = 6,
    parameter int            DW        = 16,
    parameter int            SB        = 2,
    parameter int            PROG_CYC  = 16,
    parameter int            ERASE_CYC = 64,
    parameter int            ERS_WIN   = 24,
    parameter logic [7:0]    MAKER_ID  = 8'h5A,
    parameter logic [7:0]    DEV_ID    = 8'hB9,
    parameter logic [AW-1:0] UL_A1     = 'h15,
    parameter logic [AW-1:0] UL_A2     = 'h2A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          byte_n,
    input  logic          byte_sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    localparam int NSECT = 1 << SB;
    localparam int HB    = DW / 2;
    localparam int MAXC  = (ERASE_CYC > PROG_CYC) ?
                           ((ERASE_CYC > ERS_WIN) ? ERASE_CYC : ERS_WIN) :
                           ((PROG_CYC > ERS_WIN) ? PROG_CYC : ERS_WIN);
    localparam int CW    = $clog2(MAXC + 1);

    logic             tmr_done, tmr_start, tmr_hold;
    logic [CW-1:0]    tmr_len;
    logic             prog_we, ers_we, busy, ident;
    logic [AW-1:0]    prog_addr;
    logic [DW-1:0]    prog_word, rd_word;
    logic [NSECT-1:0] ers_sect;
    logic [7:0]       stat;

    flash_cmd_fsm #(
        .AW(AW), .DW(DW), .SB(SB), .CW(CW),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .ERS_WIN(ERS_WIN),
        .UL_A1(UL_A1), .UL_A2(UL_A2)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_n(byte_n), .byte_sel(byte_sel), .addr(addr), .din(din),
        .tmr_done(tmr_done), .tmr_start(tmr_start), .tmr_len(tmr_len),
        .tmr_hold(tmr_hold), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_word(prog_word), .ers_we(ers_we), .ers_sect(ers_sect),
        .busy(busy), .ident(ident), .stat(stat)
    );

    flash_op_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len),
        .hold(tmr_hold), .done(tmr_done)
    );

    flash_store #(.AW(AW), .DW(DW), .SB(SB)) u_store (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_word(prog_word), .ers_we(ers_we), .ers_sect(ers_sect),
        .rd_addr(addr), .rd_data(rd_word)
    );

    always_comb begin
        if (busy)
            dout = {{(DW-8){1'b0}}, stat};
        else if (ident)
            dout = {{(DW-8){1'b0}},
                    (addr[1:0] == 2'd0) ? MAKER_ID :
                    (addr[1:0] == 2'd1) ? DEV_ID : 8'h00};
        else if (!byte_n)
            dout = {{HB{1'b0}}, byte_sel ? rd_word[DW-1 -: HB] : rd_word[HB-1:0]};
        else
            dout = rd_word;
    end

    assign dout_en = rst_n && !ce_n && !oe_n && we_n;

endmodule

// File: tb/flash_cmd_top_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic        byte_n = 1'b1, byte_sel = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_en;

    always #4 clk = ~clk;

    flash_cmd_top dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_n(byte_n), .byte_sel(byte_sel), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic        tog_m = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    event        smp_ev;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as the design presents read data
    initial begin
        forever begin
            @(smp_ev);
            chk(tag_q.pop_front(), dout_en ? dout : 16'hxxxx, exp_q.pop_front());
        end
    end

    task automatic wr(logic [5:0] a, logic [15:0] d, logic oe = 1'b1);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; oe_n = oe;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(logic [5:0] a, logic [15:0] exp, string tag);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); #1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        ->smp_ev;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_stat(logic b7, string tag);
        logic [15:0] e;
        e = {8'h00, b7, tog_m, 6'b0};
        tog_m = !tog_m;
        rd(6'h00, e, tag);
    endtask

    task automatic keys();
        wr(6'h15, 16'h00AA);
        wr(6'h2A, 16'h0055);
    endtask

    task automatic prog(logic [5:0] a, logic [15:0] d);
        keys(); wr(6'h15, 16'h00A0); wr(a, d);
    endtask

    task automatic ers_setup();
        keys(); wr(6'h15, 16'h0080); keys();
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        // R10: outputs float while reset is held, even with a read strobe
        idle(2);
        ce_n = 1'b0; oe_n = 1'b0; #1;
        chk("R10 reset float", {15'd0, dout_en}, 16'd0);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; rst_n = 1'b1;
        idle(2);

        // R8: whole-device erase, status read while busy
        ers_setup(); wr(6'h15, 16'h0010);
        rd_stat(1'b0, "R6 erase status");
        idle(100);  // R11: ce_n high throughout
        rd(6'h00, 16'hFFFF, "R8 chip erase low");
        rd(6'h3F, 16'hFFFF, "R8 R11 chip erase high");

        // R2 / R6: standard program, status complement and toggle
        prog(6'h05, 16'h1234);
        rd_stat(1'b1, "R6 program status first");
        rd_stat(1'b1, "R6 program status toggled");
        idle(40);
        rd(6'h05, 16'h1234, "R2 program result");
        prog(6'h05, 16'hFF0F);
        idle(40);
        rd(6'h05, 16'h1204, "R2 program clears only");

        // R3: wrong unlock address aborts the sequence
        wr(6'h15, 16'h00AA); wr(6'h2B, 16'h0055); wr(6'h15, 16'h00A0);
        wr(6'h06, 16'h0000);
        idle(30);
        rd(6'h06, 16'hFFFF, "R3 broken sequence");

        // R1: data strobe with oe_n low is not a write
        keys(); wr(6'h15, 16'h00A0);
        wr(6'h07, 16'h0000, 1'b0);
        idle(30);
        rd(6'h07, 16'hFFFF, "R1 oe low write ignored");
        wr(6'h07, 16'hFFFF);
        idle(40);

        // R5: identifier mode
        keys(); wr(6'h15, 16'h0090);
        rd(6'h00, 16'h005A, "R5 maker code");
        rd(6'h01, 16'h00B9, "R5 device code");
        wr(6'h00, 16'h00F0);
        rd(6'h05, 16'h1204, "R5 back to array");

        // R4: fast-program mode
        keys(); wr(6'h15, 16'h0020);
        wr(6'h00, 16'h00A0); wr(6'h10, 16'hABCD);
        idle(40);
        rd(6'h10, 16'hABCD, "R4 two-write program");
        wr(6'h00, 16'h0090); wr(6'h00, 16'h0000);
        wr(6'h00, 16'h00A0); wr(6'h11, 16'h0000);
        idle(30);
        rd(6'h11, 16'hFFFF, "R4 mode left");

        // R12: byte-wide program and reads
        byte_n = 1'b0; byte_sel = 1'b1;
        prog(6'h12, 16'h003C);
        idle(40);
        rd(6'h12, 16'h003C, "R12 upper byte");
        byte_sel = 1'b0;
        rd(6'h12, 16'h00FF, "R12 lower byte");
        byte_n = 1'b1;
        rd(6'h12, 16'h3CFF, "R12 word view");

        // R7: two-sector erase
        prog(6'h30, 16'h5555);
        idle(40);
        ers_setup(); wr(6'h10, 16'h0030); wr(6'h30, 16'h0030);
        rd_stat(1'b0, "R6 R7 window status");
        idle(150);
        rd(6'h10, 16'hFFFF, "R7 sector1 erased");
        rd(6'h12, 16'hFFFF, "R7 sector1 erased");
        rd(6'h30, 16'hFFFF, "R7 sector3 erased");
        rd(6'h05, 16'h1204, "R7 sector0 kept");

        // R9: suspend and resume
        prog(6'h20, 16'h00F0);
        idle(40);
        ers_setup(); wr(6'h20, 16'h0030);
        idle(40);
        wr(6'h00, 16'h00B0);
        idle(200);
        rd(6'h20, 16'h00F0, "R9 suspended erase");
        wr(6'h00, 16'h0030);
        idle(150);
        rd(6'h20, 16'hFFFF, "R9 resumed erase");

        // R10: reset aborts a running program
        prog(6'h21, 16'h0000);
        @(negedge clk); rst_n = 1'b0; tog_m = 1'b0;
        ce_n = 1'b0; oe_n = 1'b0; #1;
        chk("R10 float during abort", {15'd0, dout_en}, 16'd0);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        idle(2); rst_n = 1'b1;
        idle(40);
        rd(6'h21, 16'hFFFF, "R10 program aborted");
        rd(6'h05, 16'h1204, "R10 array reads");

        idle(4);
        summary();
    end

endmodule